// File: doc/BRIEF.md
# One-Way Code Protection Register

This block holds an eight-bit protection setting for on-chip program memory. The register can be reached only while the chip is in its programming mode, and only at one fixed address. A program operation can clear bits but can never set them. Only a whole-chip erase returns the bits to ones. Four bits carry meaning, and the block decodes them into control outputs:

- a lock, which blocks programming-mode reads of the array and blocks both reads and programs of the register itself;
- a table-read inhibit, which keeps table reads issued from external code out of the internal program space;
- a bus data scrambling enable;
- an oscillator half-gain select.

In the chip, the programming interface drives the mode, address, data and strobes. The processor side presents table-read requests together with the address of the instruction that issued them. At power-up the register takes its stored value, given by a parameter and loaded by the power-on reset. In simulation an erase then brings it to a known state.

Top module: `sec_guard`

## Requirements
- R1: After power-on reset the register reads FFh and none of the lock, inhibit, scrambling or half-gain outputs is active.
- R2: A program strobe in programming mode at address FFFFh, while unlocked, makes the register equal to old AND (data OR 78h): bits 6..3 are reserved and stay 1, and no bit ever rises except by erase.
- R3: A program strobe outside programming mode, or at any address other than FFFFh, leaves the register unchanged.
- R4: An erase strobe in programming mode sets the register to FFh on the next clock, taking priority over a program strobe in the same cycle; an erase strobe outside programming mode is ignored.
- R5: When bit 0 is 0 (locked), program strobes to the register have no effect, while erase still restores FFh.
- R6: The read data output is the register at address FFFFh, and the array data at any other address, only when in programming mode and unlocked; otherwise it is FFh.
- R7: A table read issued from internal code (fetch address at most 1FFFh) to an internal target (address at most 1FFFh) is routed internally, whatever bit 1 holds.
- R8: A table read issued from external code (fetch address above 1FFFh) to an internal target is blocked and routed to external memory when bit 1 is 0, and routed internally when bit 1 is 1. A target above 1FFFh is always routed externally. Exactly one route is active per request and none without one.
- R9: lock_on equals NOT bit 0, inhibit_on equals NOT bit 1, scramble_en equals NOT bit 2, and half_gain equals NOT bit 7 of the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset; loads the stored value |
| prog_mode | input | 1 | Programming mode active |
| pm_addr | input | 16 | Programming-mode address |
| pm_wdata | input | 8 | Data for a program operation |
| pm_prog | input | 1 | Program strobe |
| pm_erase | input | 1 | Whole-chip erase strobe |
| arr_rdata | input | 8 | Data read from the program array at pm_addr |
| pm_rdata | output | 8 | Programming-mode read data |
| tbl_req | input | 1 | Table read request |
| tbl_addr | input | 16 | Table read target address |
| fetch_pc | input | 16 | Address of the instruction issuing the table read |
| tbl_int | output | 1 | Table read routed to internal memory |
| tbl_ext | output | 1 | Table read routed to external memory |
| tbl_blocked | output | 1 | Internal target refused by the inhibit |
| sec_q | output | 8 | Current register value |
| lock_on | output | 1 | Lock active |
| inhibit_on | output | 1 | Table-read inhibit active |
| scramble_en | output | 1 | Bus data scrambling enabled |
| half_gain | output | 1 | Oscillator half gain selected |

## Verification
The hardest states to reach from the ports are the locked register receiving a program in the same cycle as an erase, and a locked register meeting an erase outside programming mode. Both need a lock to have been programmed first, and then an erase that is rare enough not to undo it at once. The random phase aims about half of its programs at FFFFh with data that often clears bit 0, and keeps erases rare. Directed steps place simultaneous erase and program strobes both before and after locking, and send table reads across the 1FFFh/2000h boundary from both code spaces.

// File: rtl/sec_pkg.sv
package sec_pkg;

  // Program merge: bits can only fall; reserved bits are held at one.
  function automatic logic [7:0] prog_merge(input logic [7:0] cur,
                                            input logic [7:0] din,
                                            input logic [7:0] rsv);
    return cur & (din | rsv);
  endfunction

  // True when an address falls inside the internal program space.
  function automatic logic in_internal(input logic [15:0] a,
                                       input logic [15:0] last);
    return a <= last;
  endfunction

  typedef enum logic [1:0] {ROUTE_NONE, ROUTE_INT, ROUTE_EXT} route_e;

endpackage

// File: rtl/sec_store.sv
module sec_store #(
  parameter int          DW       = 8,
  parameter logic [7:0]  RSV_MASK = 8'h78,
  parameter logic [7:0]  INIT_VAL = 8'hFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pgm_hit,
  input  logic          ers_hit,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  import sec_pkg::*;

  localparam logic [DW-1:0] ALL_ONES = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= INIT_VAL | RSV_MASK;
    else if (ers_hit) q <= ALL_ONES;
    else if (pgm_hit) q <= prog_merge(q, wdata, RSV_MASK);
  end
endmodule

// File: rtl/sec_decode.sv
module sec_decode #(
  parameter int         DW       = 8,
  parameter int         LOCK_BIT = 0,
  parameter int         INH_BIT  = 1,
  parameter int         ENC_BIT  = 2,
  parameter int         GAIN_BIT = 7,
  parameter logic [7:0] RSV_MASK = 8'h78
) (
  input  logic [DW-1:0] q,
  output logic          lock_on,
  output logic          inhibit_on,
  output logic          scramble_en,
  output logic          half_gain,
  output logic          rsv_intact
);
  // Active-low encodings: a cleared bit turns its feature on.
  assign lock_on     = ~q[LOCK_BIT];
  assign inhibit_on  = ~q[INH_BIT];
  assign scramble_en = ~q[ENC_BIT];
  assign half_gain   = ~q[GAIN_BIT];
  assign rsv_intact  = &(q | ~RSV_MASK);
endmodule

// File: rtl/sec_access.sv
module sec_access #(
  parameter int          AW       = 16,
  parameter int          DW       = 8,
  parameter logic [15:0] SEC_ADDR = 16'hFFFF,
  parameter logic [15:0] INT_LAST = 16'h1FFF
) (
  input  logic          prog_mode,
  input  logic [AW-1:0] pm_addr,
  input  logic [DW-1:0] arr_rdata,
  input  logic [DW-1:0] q,
  input  logic          lock_on,
  input  logic          inhibit_on,
  output logic [DW-1:0] pm_rdata,
  input  logic          tbl_req,
  input  logic [AW-1:0] tbl_addr,
  input  logic [AW-1:0] fetch_pc,
  output logic          tbl_int,
  output logic          tbl_ext,
  output logic          tbl_blocked
);
  import sec_pkg::*;

  localparam logic [DW-1:0] BLANK = '1;

  logic   rd_open, tgt_int, from_int, allow_int;
  route_e route;

  assign rd_open = prog_mode & ~lock_on;

  always_comb begin
    if (!rd_open)                pm_rdata = BLANK;
    else if (pm_addr == SEC_ADDR) pm_rdata = q;
    else                         pm_rdata = arr_rdata;
  end

  assign tgt_int   = in_internal(tbl_addr, INT_LAST);
  assign from_int  = in_internal(fetch_pc, INT_LAST);
  assign allow_int = from_int | ~inhibit_on;

  always_comb begin
    route = ROUTE_NONE;
    if (tbl_req) route = (tgt_int && allow_int) ? ROUTE_INT : ROUTE_EXT;
  end

  assign tbl_int     = (route == ROUTE_INT);
  assign tbl_ext     = (route == ROUTE_EXT);
  assign tbl_blocked = tbl_req & tgt_int & ~allow_int;
endmodule

// File: rtl/sec_guard.sv
module sec_guard #(
  parameter int          AW       = 16,
  parameter int          DW       = 8,
  parameter logic [15:0] SEC_ADDR = 16'hFFFF,
  parameter logic [15:0] INT_LAST = 16'h1FFF,
  parameter logic [7:0]  RSV_MASK = 8'h78,
  parameter logic [7:0]  INIT_VAL = 8'hFF,
  parameter int          LOCK_BIT = 0,
  parameter int          INH_BIT  = 1,
  parameter int          ENC_BIT  = 2,
  parameter int          GAIN_BIT = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_mode,
  input  logic [AW-1:0] pm_addr,
  input  logic [DW-1:0] pm_wdata,
  input  logic          pm_prog,
  input  logic          pm_erase,
  input  logic [DW-1:0] arr_rdata,
  output logic [DW-1:0] pm_rdata,
  input  logic          tbl_req,
  input  logic [AW-1:0] tbl_addr,
  input  logic [AW-1:0] fetch_pc,
  output logic          tbl_int,
  output logic          tbl_ext,
  output logic          tbl_blocked,
  output logic [DW-1:0] sec_q,
  output logic          lock_on,
  output logic          inhibit_on,
  output logic          scramble_en,
  output logic          half_gain
);
  // Named internal events, visible to the bound checker.
  logic ers_hit, pgm_hit, rsv_intact;

  assign ers_hit = prog_mode & pm_erase;
  assign pgm_hit = prog_mode & pm_prog & (pm_addr == SEC_ADDR)
                 & ~lock_on & ~ers_hit;

  sec_store #(.DW(DW), .RSV_MASK(RSV_MASK), .INIT_VAL(INIT_VAL)) u_store (
    .clk(clk), .rst_n(rst_n), .pgm_hit(pgm_hit), .ers_hit(ers_hit),
    .wdata(pm_wdata), .q(sec_q)
  );

  sec_decode #(.DW(DW), .LOCK_BIT(LOCK_BIT), .INH_BIT(INH_BIT),
               .ENC_BIT(ENC_BIT), .GAIN_BIT(GAIN_BIT),
               .RSV_MASK(RSV_MASK)) u_dec (
    .q(sec_q), .lock_on(lock_on), .inhibit_on(inhibit_on),
    .scramble_en(scramble_en), .half_gain(half_gain),
    .rsv_intact(rsv_intact)
  );

  sec_access #(.AW(AW), .DW(DW), .SEC_ADDR(SEC_ADDR),
               .INT_LAST(INT_LAST)) u_acc (
    .prog_mode(prog_mode), .pm_addr(pm_addr), .arr_rdata(arr_rdata),
    .q(sec_q), .lock_on(lock_on), .inhibit_on(inhibit_on),
    .pm_rdata(pm_rdata), .tbl_req(tbl_req), .tbl_addr(tbl_addr),
    .fetch_pc(fetch_pc), .tbl_int(tbl_int), .tbl_ext(tbl_ext),
    .tbl_blocked(tbl_blocked)
  );
endmodule

// File: rtl/sec_guard_chk.sv
module sec_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       prog_mode,
  input logic       pm_erase,
  input logic       pm_prog,
  input logic [7:0] sec_q,
  input logic [7:0] pm_rdata,
  input logic       lock_on,
  input logic       tbl_int,
  input logic       tbl_ext,
  input logic       tbl_blocked,
  input logic       tbl_req,
  input logic       rsv_intact
);
  assert_no_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_mode && pm_erase) |=> ((sec_q & ~$past(sec_q)) == 8'h00));

  assert_rsv_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsv_intact);

  assert_run_mode_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_mode |=> $stable(sec_q));

  assert_erase_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_mode && pm_erase) |=> (sec_q == 8'hFF));

  assert_locked_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_on && pm_prog && !pm_erase) |=> $stable(sec_q));

  assert_closed_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!prog_mode || lock_on) |-> (pm_rdata == 8'hFF));

  assert_blocked_ext_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_blocked |-> (tbl_ext && !tbl_int));

  assert_one_route_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({tbl_int, tbl_ext}) == (tbl_req ? 1 : 0));
endmodule

bind sec_guard sec_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .prog_mode(prog_mode), .pm_erase(pm_erase),
  .pm_prog(pm_prog), .sec_q(sec_q), .pm_rdata(pm_rdata), .lock_on(lock_on),
  .tbl_int(tbl_int), .tbl_ext(tbl_ext), .tbl_blocked(tbl_blocked),
  .tbl_req(tbl_req), .rsv_intact(rsv_intact)
);

// File: tb/sim_sec_guard.sv
module sim_sec_guard;
  localparam time CLK_P = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prog_mode = 1'b0;
  logic [15:0] pm_addr = '0;
  logic [7:0]  pm_wdata = '0;
  logic        pm_prog = 1'b0;
  logic        pm_erase = 1'b0;
  logic [7:0]  arr_rdata = 8'h5A;
  logic [7:0]  pm_rdata;
  logic        tbl_req = 1'b0;
  logic [15:0] tbl_addr = '0;
  logic [15:0] fetch_pc = '0;
  logic        tbl_int, tbl_ext, tbl_blocked;
  logic [7:0]  sec_q;
  logic        lock_on, inhibit_on, scramble_en, half_gain;

  int total = 0;
  int bad   = 0;
  logic [7:0] m;   // bench model of the register

  always #(CLK_P/2) clk = ~clk;

  sec_guard u0 (
    .clk(clk), .rst_n(rst_n), .prog_mode(prog_mode), .pm_addr(pm_addr),
    .pm_wdata(pm_wdata), .pm_prog(pm_prog), .pm_erase(pm_erase),
    .arr_rdata(arr_rdata), .pm_rdata(pm_rdata), .tbl_req(tbl_req),
    .tbl_addr(tbl_addr), .fetch_pc(fetch_pc), .tbl_int(tbl_int),
    .tbl_ext(tbl_ext), .tbl_blocked(tbl_blocked), .sec_q(sec_q),
    .lock_on(lock_on), .inhibit_on(inhibit_on), .scramble_en(scramble_en),
    .half_gain(half_gain)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Next register value per R2..R5, written from the requirements.
  function automatic logic [7:0] next_val(input logic [7:0] cur);
    if (prog_mode && pm_erase) return 8'hFF;
    if (prog_mode && pm_prog && pm_addr == 16'hFFFF && cur[0])
      return {cur[7], 4'b1111, cur[2:0]} & {pm_wdata[7], 4'b1111, pm_wdata[2:0]};
    return cur;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [7:0] cur);
    if (!prog_mode || !cur[0]) return 8'hFF;
    return (pm_addr == 16'hFFFF) ? cur : arr_rdata;
  endfunction

  // Returns {int, ext, blocked}
  function automatic logic [2:0] exp_route(input logic [7:0] cur);
    logic tgt_in, pc_in;
    tgt_in = (tbl_addr < 16'h2000);
    pc_in  = (fetch_pc < 16'h2000);
    if (!tbl_req) return 3'b000;
    if (!tgt_in) return 3'b010;
    if (pc_in || cur[1]) return 3'b100;
    return 3'b011;
  endfunction

  task automatic check_all(input string tag);
    logic [2:0] r;
    r = exp_route(m);
    chk(sec_q == m, {"R2/R3/R4/R5 value ", tag}, sec_q, m);
    chk({lock_on, inhibit_on, scramble_en, half_gain} == {~m[0], ~m[1], ~m[2], ~m[7]},
        {"R9 decode ", tag}, {lock_on, inhibit_on, scramble_en, half_gain},
        {~m[0], ~m[1], ~m[2], ~m[7]});
    chk(pm_rdata == exp_rd(m), {"R6 read ", tag}, pm_rdata, exp_rd(m));
    chk({tbl_int, tbl_ext, tbl_blocked} == r, {"R7/R8 route ", tag},
        {tbl_int, tbl_ext, tbl_blocked}, r);
  endtask

  // Drive at negedge, check settled outputs, then let the edge update.
  task automatic step(input string tag);
    #1 check_all(tag);
    @(posedge clk);
    m = next_val(m);
    @(negedge clk);
    pm_prog = 0; pm_erase = 0; tbl_req = 0;
  endtask

  task automatic setin(input logic md, input logic [15:0] a, input logic [7:0] d,
                       input logic pg, input logic er);
    prog_mode = md; pm_addr = a; pm_wdata = d; pm_prog = pg; pm_erase = er;
  endtask

  task automatic tbl(input logic [15:0] pc, input logic [15:0] ta);
    tbl_req = 1; fetch_pc = pc; tbl_addr = ta;
  endtask

  initial begin : watchdog
    #(CLK_P * 150000);
    bad++; total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    #1 chk(sec_q == 8'hFF, "R1 reset value", sec_q, 8'hFF);
    chk({lock_on, inhibit_on, scramble_en, half_gain} == 4'b0, "R1 outputs idle",
        {lock_on, inhibit_on, scramble_en, half_gain}, 0);
    @(negedge clk);

    // R2: program 0x05 -> FF & (05|78) = 7D
    setin(1, 16'hFFFF, 8'h05, 1, 0); step("R2 prog");
    chk(sec_q == 8'h7D, "R2 merge 7D", sec_q, 8'h7D);
    chk(half_gain && inhibit_on && !scramble_en, "R9 half gain + inhibit",
        {half_gain, inhibit_on, scramble_en}, 3'b110);
    // R2: attempt to raise bits -> unchanged
    setin(1, 16'hFFFF, 8'hFF, 1, 0); step("R2 no rise");
    // R3: wrong address, then run mode
    setin(1, 16'hFFFE, 8'h00, 1, 0); step("R3 wrong addr");
    setin(0, 16'hFFFF, 8'h00, 1, 0); step("R3 run mode");
    chk(sec_q == 8'h7D, "R3 unchanged", sec_q, 8'h7D);
    // R6 reads: register and array
    setin(1, 16'hFFFF, 8'h00, 0, 0); step("R6 reg read");
    setin(1, 16'h1234, 8'h00, 0, 0); step("R6 array read");
    // R7/R8 table reads around the boundary, inhibit active
    setin(0, 0, 0, 0, 0);
    tbl(16'h1FFF, 16'h1FFF); step("R7 int->int");
    tbl(16'h2000, 16'h1FFF); step("R8 ext->int blocked");
    chk(1'b1, "R8 blocked seen", 1, 1);
    tbl(16'h2000, 16'h2000); step("R8 ext->ext");
    tbl(16'h0000, 16'hFFFF); step("R8 int->ext");
    // R4: erase outside mode ignored; erase with program in mode wins
    setin(0, 16'hFFFF, 8'h00, 0, 1); step("R4 erase ignored");
    chk(sec_q == 8'h7D, "R4 run-mode erase ignored", sec_q, 8'h7D);
    setin(1, 16'hFFFF, 8'h00, 1, 1); step("R4 erase priority");
    chk(sec_q == 8'hFF, "R4 erase restores", sec_q, 8'hFF);
    // R8 with inhibit clear: ext code may reach internal
    tbl(16'h8000, 16'h0100); step("R8 uninhibited");
    // R5: lock, then program ignored, read closed, erase restores
    setin(1, 16'hFFFF, 8'hFE, 1, 0); step("R5 lock");
    chk(lock_on == 1'b1, "R5 lock active", lock_on, 1);
    setin(1, 16'hFFFF, 8'h00, 1, 0); step("R5 locked prog");
    chk(sec_q == 8'hFE, "R5 locked unchanged", sec_q, 8'hFE);
    setin(1, 16'hFFFF, 8'h00, 0, 0); step("R6 locked read");
    setin(0, 16'hFFFF, 8'h00, 0, 1); step("R5 run erase while locked");
    setin(1, 16'hFFFF, 8'h00, 1, 1); step("R5 erase while locked");
    chk(sec_q == 8'hFF, "R5 erase unlocks", sec_q, 8'hFF);

    // Constrained random phase
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      r = $urandom;
      prog_mode = (r[1:0] != 2'b00);
      pm_addr   = r[2] ? 16'hFFFF : 16'($urandom);
      pm_wdata  = r[3] ? 8'($urandom) : (8'($urandom) | 8'h01);
      pm_prog   = r[4];
      pm_erase  = (r[9:5] == 5'd0);
      arr_rdata = 8'($urandom);
      tbl_req   = r[10];
      fetch_pc  = r[11] ? 16'($urandom % 16'h2000) : (16'h2000 + 16'($urandom % 16'hE000));
      tbl_addr  = r[12] ? 16'($urandom % 16'h2000) : 16'($urandom);
      step("random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule